// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block does the arbitration stage of a multi-source interrupt controller, one arbitration per processor. Every source has a request line, a 4-bit priority and a routing mask that names the processors allowed to service it. The low source numbers are the software-settable requests and the higher numbers are the peripheral requests. The block treats both kinds the same way. For each processor it looks at the asserted requests routed to it and finds the highest priority among them. When several of these requests share that priority, the one with the lowest source number wins.

The winning source number is encoded as a 10-bit vector. The processor's interrupt line is raised only if the winner's priority is strictly above the priority that processor is currently running at. The vector is presented for the acknowledge path. It is also presented on a second output that is meant for direct vectoring, and that output is live only while the processor's hardware-vector mode bit is set. All outputs are registered. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `irq_prio_arb`

## Requirements
- R1: While reset is asserted, and after its release until a request wins, every interrupt line is 0 and every vector output is 0.
- R2: Source i takes part in processor p's arbitration only when bit p of its routing mask is 1. A source whose mask has several bits set takes part for each of those processors independently.
- R3: Among the asserted, routed sources, the one with the numerically largest priority wins.
- R4: When several asserted, routed sources share the largest priority, the lowest source number wins, whatever order they were asserted in.
- R5: The vector is the winning source number, zero-extended to 10 bits. Software sources 0 to 31 give vectors 0 to 31, and peripheral sources give vectors 32 and up.
- R6: A source whose priority is 0 never wins and never raises an interrupt line.
- R7: A processor's interrupt line is 1 only when the winning priority is strictly greater than that processor's current priority. An equal priority does not raise it.
- R8: Outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change before that edge.
- R9: When no routed request beats the current priority, the processor's interrupt line is 0 and its acknowledge vector keeps its previous value.
- R10: With the hardware-vector mode bit set, the direct vector output follows every acknowledge-vector update and otherwise holds. With the mode bit clear, that output is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Request line of each source |
| src_pri_i | input | NUM_SRC x PRI_W | Priority of each source (0 means disabled) |
| src_route_i | input | NUM_SRC x NUM_PRC | Routing mask of each source, one bit per processor |
| cur_pri_i | input | NUM_PRC x PRI_W | Current running priority of each processor |
| hw_mode_i | input | NUM_PRC | Hardware-vector mode bit of each processor |
| irq_o | output | NUM_PRC | Interrupt line to each processor |
| ack_vec_o | output | NUM_PRC x 10 | Winning vector for the acknowledge path |
| hw_vec_o | output | NUM_PRC x 10 | Direct vector, live in hardware-vector mode |

## Verification
The assertions check the following on every cycle, against the inputs registered one edge earlier:
- a raised line points at a source that was asserted, routed to that processor, of non-zero priority and strictly above the current priority;
- the acknowledge vector never moves while its line is low;
- the vector stays inside the source range;
- the direct vector is 0 whenever its mode bit was clear.

The assertions cannot show that the winner is the best candidate. That is left to the bench's directed scenarios:
- the maximum and tie-break choices;
- a late-arriving lower-numbered tie that takes over;
- the equal-priority boundary of preemption;
- the one-cycle latency.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Architectural width of an interrupt vector
  localparam int unsigned VEC_W      = 10;
  // Defaults shared by the arbiter and its checker
  localparam int unsigned DFLT_SRC   = 64;
  localparam int unsigned DFLT_PRC   = 2;
  localparam int unsigned DFLT_PRI_W = 4;
endpackage

// File: rtl/irq_prio_tree.sv
// Finds the largest priority among asserted, routed, enabled sources and
// flags every source that holds it.
module irq_prio_tree #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRI_W   = 4
) (
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [NUM_SRC-1:0]            route_i,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
  output logic [PRI_W-1:0]              max_pri_o,
  output logic [NUM_SRC-1:0]            hit_o
);
  logic [NUM_SRC-1:0] part;
  logic [PRI_W-1:0]   best;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      part[i] = req_i[i] & route_i[i] & (pri_i[i] != '0);
    end
  end

  always_comb begin
    best = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (part[i] && (pri_i[i] > best)) best = pri_i[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      hit_o[i] = part[i] & (pri_i[i] == best);
    end
  end

  assign max_pri_o = best;
endmodule

// File: rtl/irq_low_pick.sv
// Picks the lowest-numbered flagged source.
module irq_low_pick #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] hit_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |hit_i;
endmodule

// File: rtl/irq_preempt_enc.sv
// Encodes the winner into a vector and decides preemption.
module irq_preempt_enc #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned PRI_W = 4,
  parameter int unsigned VEC_W = 10
) (
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PRI_W-1:0] win_pri_i,
  input  logic [PRI_W-1:0] cur_pri_i,
  output logic             fire_o,
  output logic [VEC_W-1:0] vec_o
);
  assign fire_o = any_i & (win_pri_i > cur_pri_i);
  assign vec_o  = VEC_W'(idx_i);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = DFLT_SRC,
  parameter int unsigned NUM_PRC = DFLT_PRC,
  parameter int unsigned PRI_W   = DFLT_PRI_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               req_i,
  input  logic [NUM_SRC-1:0][PRI_W-1:0]    src_pri_i,
  input  logic [NUM_SRC-1:0][NUM_PRC-1:0]  src_route_i,
  input  logic [NUM_PRC-1:0][PRI_W-1:0]    cur_pri_i,
  input  logic [NUM_PRC-1:0]               hw_mode_i,
  output logic [NUM_PRC-1:0]               irq_o,
  output logic [NUM_PRC-1:0][VEC_W-1:0]    ack_vec_o,
  output logic [NUM_PRC-1:0][VEC_W-1:0]    hw_vec_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_PRC-1:0]                fire;
  logic [NUM_PRC-1:0][VEC_W-1:0]     win_vec;

  for (genvar p = 0; p < NUM_PRC; p++) begin : g_prc
    logic [NUM_SRC-1:0] route_col;
    logic [NUM_SRC-1:0] hit;
    logic [PRI_W-1:0]   max_pri;
    logic [IDX_W-1:0]   idx;
    logic               any;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign route_col[s] = src_route_i[s][p];
    end

    irq_prio_tree #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W)) u_tree (
      .req_i     (req_i),
      .route_i   (route_col),
      .pri_i     (src_pri_i),
      .max_pri_o (max_pri),
      .hit_o     (hit)
    );

    irq_low_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .hit_i (hit),
      .idx_o (idx),
      .any_o (any)
    );

    irq_preempt_enc #(.IDX_W(IDX_W), .PRI_W(PRI_W), .VEC_W(VEC_W)) u_enc (
      .any_i     (any),
      .idx_i     (idx),
      .win_pri_i (max_pri),
      .cur_pri_i (cur_pri_i[p]),
      .fire_o    (fire[p]),
      .vec_o     (win_vec[p])
    );
  end

  // Next-state logic
  logic [NUM_PRC-1:0]             irq_q, irq_d;
  logic [NUM_PRC-1:0][VEC_W-1:0]  ack_q, ack_d, hw_q, hw_d;
  logic [NUM_PRC-1:0]             ack_en, hw_en;

  always_comb begin
    irq_d = fire;
    for (int p = 0; p < NUM_PRC; p++) begin
      ack_en[p] = fire[p];
      ack_d[p]  = win_vec[p];
      hw_en[p]  = fire[p] | ~hw_mode_i[p];
      hw_d[p]   = hw_mode_i[p] ? win_vec[p] : '0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      ack_q <= '0;
      hw_q  <= '0;
    end else if (!rst_sync_q) begin
      irq_q <= '0;
      ack_q <= '0;
      hw_q  <= '0;
    end else begin
      irq_q <= irq_d;
      for (int p = 0; p < NUM_PRC; p++) begin
        if (ack_en[p]) ack_q[p] <= ack_d[p];
        if (hw_en[p])  hw_q[p]  <= hw_d[p];
      end
    end
  end

  assign irq_o     = irq_q;
  assign ack_vec_o = ack_q;
  assign hw_vec_o  = hw_q;
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = DFLT_SRC,
  parameter int unsigned NUM_PRC = DFLT_PRC,
  parameter int unsigned PRI_W   = DFLT_PRI_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_SRC-1:0]               req_i,
  input logic [NUM_SRC-1:0][PRI_W-1:0]    src_pri_i,
  input logic [NUM_SRC-1:0][NUM_PRC-1:0]  src_route_i,
  input logic [NUM_PRC-1:0][PRI_W-1:0]    cur_pri_i,
  input logic [NUM_PRC-1:0]               hw_mode_i,
  input logic [NUM_PRC-1:0]               irq_o,
  input logic [NUM_PRC-1:0][VEC_W-1:0]    ack_vec_o,
  input logic [NUM_PRC-1:0][VEC_W-1:0]    hw_vec_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                             started;
  logic [NUM_SRC-1:0]               req_d;
  logic [NUM_SRC-1:0][PRI_W-1:0]    pri_d;
  logic [NUM_SRC-1:0][NUM_PRC-1:0]  route_d;
  logic [NUM_PRC-1:0][PRI_W-1:0]    cur_d;
  logic [NUM_PRC-1:0]               mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  always_ff @(posedge clk) begin
    req_d   <= req_i;
    pri_d   <= src_pri_i;
    route_d <= src_route_i;
    cur_d   <= cur_pri_i;
    mode_d  <= hw_mode_i;
  end

  for (genvar p = 0; p < NUM_PRC; p++) begin : g_chk
    logic [IDX_W-1:0] vi;
    assign vi = ack_vec_o[p][IDX_W-1:0];

    AST_WIN_ROUTED: assert property (@(posedge clk) disable iff (!rst_n || !started)
      irq_o[p] |-> (req_d[vi] && route_d[vi][p])); // R2
    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n || !started)
      irq_o[p] |-> (pri_d[vi] > cur_d[p])); // R7
    AST_ZERO_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n || !started)
      irq_o[p] |-> (pri_d[vi] != '0)); // R6
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !started)
      !irq_o[p] |-> $stable(ack_vec_o[p])); // R9
    AST_HW_VEC_OFF: assert property (@(posedge clk) disable iff (!rst_n || !started)
      !mode_d[p] |-> (hw_vec_o[p] == '0)); // R10
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n || !started)
      ack_vec_o[p] < VEC_W'(NUM_SRC)); // R5
  end
endmodule

bind irq_prio_arb irq_prio_arb_chk #(
  .NUM_SRC(NUM_SRC), .NUM_PRC(NUM_PRC), .PRI_W(PRI_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .src_pri_i   (src_pri_i),
  .src_route_i (src_route_i),
  .cur_pri_i   (cur_pri_i),
  .hw_mode_i   (hw_mode_i),
  .irq_o       (irq_o),
  .ack_vec_o   (ack_vec_o),
  .hw_vec_o    (hw_vec_o)
);

// File: tb/sim_irq_prio_arb.sv
`timescale 1ns/1ps
module sim_irq_prio_arb;
  localparam int NS = 64;
  localparam int NP = 2;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [NS-1:0]           req;
  logic [NS-1:0][3:0]      pri;
  logic [NS-1:0][1:0]      route;
  logic [NP-1:0][3:0]      cur;
  logic [NP-1:0]           mode;
  logic [NP-1:0]           irq;
  logic [NP-1:0][9:0]      ack;
  logic [NP-1:0][9:0]      hwv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_arb #(.NUM_SRC(NS), .NUM_PRC(NP), .PRI_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .src_pri_i(pri),
    .src_route_i(route), .cur_pri_i(cur), .hw_mode_i(mode),
    .irq_o(irq), .ack_vec_o(ack), .hw_vec_o(hwv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    req = '0; pri = '0; route = '0; cur = '0; mode = '0;
  endtask

  task automatic put(input int s, input int p, input int r);
    req[s] = 1'b1; pri[s] = 4'(p); route[s] = 2'(r);
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 1'b0;
    put(5, 3, 1);
    mode = 2'b11;
    repeat (3) step();
    chk("R1 irq0 in reset", irq[0], 0);
    chk("R1 ack0 in reset", ack[0], 0);
    chk("R1 hw0 in reset",  hwv[0], 0);
    clear_in();
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 irq after release", irq, 0);
    chk("R1 ack1 after release", ack[1], 0);
  endtask

  task automatic t_single();
    clear_in(); step();
    put(40, 5, 1);
    mode = 2'b01;
    chk("R8 irq0 before edge", irq[0], 0);
    step();
    chk("R8 irq0 after edge", irq[0], 1);
    chk("R5 ack0 peripheral vector", ack[0], 40);
    chk("R2 irq1 unrouted", irq[1], 0);
    chk("R10 hw0 follows", hwv[0], 40);
  endtask

  task automatic t_route();
    route[40] = 2'b10;
    step();
    chk("R2 irq0 after reroute", irq[0], 0);
    chk("R9 ack0 holds", ack[0], 40);
    chk("R2 irq1 after reroute", irq[1], 1);
    chk("R2 ack1", ack[1], 40);
    chk("R10 hw0 holds", hwv[0], 40);
    mode = 2'b00;
    step();
    chk("R10 hw0 cleared", hwv[0], 0);
  endtask

  task automatic t_max();
    clear_in();
    put(3, 2, 1); put(50, 9, 1); put(10, 7, 1);
    step();
    chk("R3 highest wins", ack[0], 50);
    req[50] = 1'b0;
    step();
    chk("R3 next highest", ack[0], 10);
  endtask

  task automatic t_tie();
    clear_in();
    put(60, 6, 1);
    step();
    chk("R4 single holder", ack[0], 60);
    put(12, 6, 1);
    step();
    chk("R4 later lower index wins", ack[0], 12);
    put(33, 6, 1);
    step();
    chk("R5 software vector kept", ack[0], 12);
  endtask

  task automatic t_preempt();
    clear_in();
    put(20, 6, 1);
    cur[0] = 4'd6;
    step();
    chk("R7 equal no fire", irq[0], 0);
    chk("R9 ack0 holds on equal", ack[0], 12);
    cur[0] = 4'd5;
    step();
    chk("R7 higher fires", irq[0], 1);
    chk("R7 vector loaded", ack[0], 20);
    pri[20] = 4'd15; cur[0] = 4'd15;
    step();
    chk("R7 max equal no fire", irq[0], 0);
  endtask

  task automatic t_zero();
    clear_in();
    put(7, 0, 3);
    step();
    chk("R6 zero pri p0", irq[0], 0);
    chk("R6 zero pri p1", irq[1], 0);
    put(63, 1, 1);
    step();
    chk("R6 zero pri loses", ack[0], 63);
  endtask

  task automatic t_both();
    clear_in();
    put(25, 4, 3);
    step();
    chk("R2 both irq", irq, 3);
    chk("R2 both ack0", ack[0], 25);
    chk("R2 both ack1", ack[1], 25);
    cur[0] = 4'd4; cur[1] = 4'd3;
    step();
    chk("R7 per-processor current p0", irq[0], 0);
    chk("R7 per-processor current p1", irq[1], 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_route();
    t_max();
    t_tie();
    t_preempt();
    t_zero();
    t_both();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule